// File: doc/BRIEF.md
# Sub-Sector Cluster Track Lookup

This block serves one cluster of eight sub-sectors in a muon trigger pipeline. Each clock it takes one radial hit (sub-sector position and bending deviation) and two azimuthal hits (each a deviation with its own hit flag). For each azimuthal hit it forms a lookup address from the radial position, the azimuthal input index, the radial deviation and that azimuthal deviation. It reads a writable table that holds a momentum level and a charge sign for that address. Of the two candidates it keeps the one with the higher momentum level and reports it as a registered 4-bit code.

The table is loaded at run time through a host write port while the pipeline is stopped (`run` low). With `run` high the block accepts a new input word every clock with no dead time. The synchronous table read adds one stage, so the latency is fixed at two clocks. The deviation widths are parameters. The default gives a 10-bit address; a full-size cluster uses widths that add up to a 19-bit address (for example `RDEV_W`=7, `PDEV_W`=8).

Top module: `cluster_track_lut`

## Requirements
- R1: The lookup address for azimuthal input i (0 or 1) is {r_pos, i, r_dev, phi_dev_i}, most significant field first. Bit 3 of a table entry is the charge sign and bits 2:0 are the momentum level.
- R2: The result code is 0 when there is no track. Otherwise it is {sign, level}, with a level from 1 to 6 taken from the winning entry.
- R3: A table entry whose level field is 0 or 7 yields no candidate, so the output level never exceeds 6.
- R4: Candidate i exists only when `r_hit` and `phi_hit[i]` are both 1. With neither candidate present the code is 0.
- R5: The candidate with the higher level is reported. On equal levels, candidate 0 is reported along with its sign.
- R6: `out_vld` equals `in_vld & run` from two clocks earlier, and `out_code` is 0 whenever `out_vld` is 0.
- R7: Input words on consecutive clocks each produce their own result two clocks later, with no dead cycles.
- R8: A host write stores `host_data` at `host_addr` only when `run` is 0. A write issued while `run` is 1 leaves the table unchanged.
- R9: After reset, `out_vld` and `out_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Pipeline enable; host writes blocked while high |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | ADDR_W | Host table write address |
| host_data | input | 4 | Host table entry {sign, level} |
| in_vld | input | 1 | Input word valid |
| r_hit | input | 1 | Radial hit present |
| r_pos | input | 3 | Radial sub-sector index within the cluster |
| r_dev | input | RDEV_W | Radial deviation |
| phi_hit | input | 2 | Azimuthal hit flags, one per input |
| phi_dev0 | input | PDEV_W | Deviation of azimuthal input 0 |
| phi_dev1 | input | PDEV_W | Deviation of azimuthal input 1 |
| out_vld | output | 1 | Result valid |
| out_code | output | 4 | Result {sign, level}, 0 for no track |

## Verification
The hardest situation to reach is a write that arrives in the same cycle as an active lookup of that same address while `run` is high. Random stimulus seldom lines those up, so a directed step issues such a write and a lookup of the target at once. It then looks the address up again and expects the old entry. Equal-level ties and level-7 entries are also rare in a hashed table, so directed writes plant them just before the lookups that use them. A seeded random phase then mixes back-to-back lookups with stopped intervals that reload entries.

// File: rtl/cluster_track_lut.sv
module cluster_track_lut #(
  parameter  int RDEV_W = 3,
  parameter  int PDEV_W = 3,
  localparam int ADDR_W = 3 + 1 + RDEV_W + PDEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_data,
  input  logic              in_vld,
  input  logic              r_hit,
  input  logic [2:0]        r_pos,
  input  logic [RDEV_W-1:0] r_dev,
  input  logic [1:0]        phi_hit,
  input  logic [PDEV_W-1:0] phi_dev0,
  input  logic [PDEV_W-1:0] phi_dev1,
  output logic              out_vld,
  output logic [3:0]        out_code
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [3:0] lut [DEPTH];
  logic [3:0] rd0, rd1;
  logic       v1;
  logic [1:0] h1;
  logic [2:0] l0, l1, lw;
  logic       sw;

  wire [ADDR_W-1:0] a0 = {r_pos, 1'b0, r_dev, phi_dev0};
  wire [ADDR_W-1:0] a1 = {r_pos, 1'b1, r_dev, phi_dev1};

  always_ff @(posedge clk) begin
    if (host_we && !run) lut[host_addr] <= host_data;
    rd0 <= lut[a0];
    rd1 <= lut[a1];
  end

  assign l0 = (h1[0] && rd0[2:0] != 3'd7) ? rd0[2:0] : 3'd0;
  assign l1 = (h1[1] && rd1[2:0] != 3'd7) ? rd1[2:0] : 3'd0;
  assign lw = (l1 > l0) ? l1 : l0;
  assign sw = (l1 > l0) ? rd1[3] : rd0[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1       <= 1'b0;
      h1       <= 2'b00;
      out_vld  <= 1'b0;
      out_code <= 4'd0;
    end else begin
      v1       <= in_vld && run;
      h1       <= phi_hit & {2{r_hit}};
      out_vld  <= v1;
      out_code <= (v1 && lw != 3'd0) ? {sw, lw} : 4'd0;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r6_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_vld == $past(in_vld && run, 2)));
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_code == 4'd0));
  a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_code[2:0] != 3'd7);
  a_r2_sign_needs_track: assert property (@(posedge clk) disable iff (!rst_n)
    (out_code[2:0] == 3'd0) |-> !out_code[3]);
endmodule

// File: tb/cluster_track_lut_tb.sv
module cluster_track_lut_tb;
  localparam int RDEV_W = 3;
  localparam int PDEV_W = 3;
  localparam int ADDR_W = 4 + RDEV_W + PDEV_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0, run = 0, host_we = 0, in_vld = 0, r_hit = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [3:0] host_data = '0;
  logic [2:0] r_pos = '0;
  logic [RDEV_W-1:0] r_dev = '0;
  logic [1:0] phi_hit = '0;
  logic [PDEV_W-1:0] phi_dev0 = '0, phi_dev1 = '0;
  logic out_vld;
  logic [3:0] out_code;

  cluster_track_lut #(.RDEV_W(RDEV_W), .PDEV_W(PDEV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .in_vld(in_vld), .r_hit(r_hit), .r_pos(r_pos), .r_dev(r_dev),
    .phi_hit(phi_hit), .phi_dev0(phi_dev0), .phi_dev1(phi_dev1),
    .out_vld(out_vld), .out_code(out_code));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [3:0] tbl [DEPTH];
  logic e1_v = 0, e2_v = 0;
  logic [3:0] e1_c = 0, e2_c = 0;
  string e1_t = "R9", e2_t = "R9";

  function automatic logic [2:0] lvl_of(logic hit, logic [3:0] e);
    return (hit && e[2:0] != 3'd7) ? e[2:0] : 3'd0;
  endfunction

  function automatic logic [3:0] model(logic v, logic rn, logic rh, logic [2:0] rp,
      logic [RDEV_W-1:0] rd, logic [1:0] ph, logic [PDEV_W-1:0] p0, logic [PDEV_W-1:0] p1);
    logic [3:0] t0, t1;
    logic [2:0] l0, l1;
    if (!(v && rn)) return 4'd0;
    t0 = tbl[{rp, 1'b0, rd, p0}];
    t1 = tbl[{rp, 1'b1, rd, p1}];
    l0 = lvl_of(rh && ph[0], t0);
    l1 = lvl_of(rh && ph[1], t1);
    if (l1 > l0) return {t1[3], l1};
    if (l0 == 0) return 4'd0;
    return {t0[3], l0};
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(string tag, logic rn, logic we, logic [ADDR_W-1:0] wa, logic [3:0] wd,
      logic v, logic rh, logic [2:0] rp, logic [RDEV_W-1:0] rd, logic [1:0] ph,
      logic [PDEV_W-1:0] p0, logic [PDEV_W-1:0] p1);
    @(negedge clk);
    check({e2_t, " vld"}, {3'd0, out_vld}, {3'd0, e2_v});
    check({e2_t, " code"}, out_code, e2_c);
    e2_v = e1_v; e2_c = e1_c; e2_t = e1_t;
    run = rn; host_we = we; host_addr = wa; host_data = wd;
    in_vld = v; r_hit = rh; r_pos = rp; r_dev = rd; phi_hit = ph; phi_dev0 = p0; phi_dev1 = p1;
    e1_v = v && rn; e1_c = model(v, rn, rh, rp, rd, ph, p0, p1); e1_t = tag;
    if (we && !rn) tbl[wa] = wd;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [3:0] d);
    cyc("R8", 1'b0, 1'b1, a, d, 1'b0, 1'b0, 3'd0, '0, 2'b00, '0, '0);
  endtask

  task automatic look(string tag, logic rh, logic [2:0] rp, logic [RDEV_W-1:0] rd,
      logic [1:0] ph, logic [PDEV_W-1:0] p0, logic [PDEV_W-1:0] p1);
    cyc(tag, 1'b1, 1'b0, '0, 4'd0, 1'b1, rh, rp, rd, ph, p0, p1);
  endtask

  task automatic idle(string tag, logic rn);
    cyc(tag, rn, 1'b0, '0, 4'd0, 1'b0, 1'b0, 3'd0, '0, 2'b00, '0, '0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    check("R9 vld", {3'd0, out_vld}, 4'd0);
    check("R9 code", out_code, 4'd0);
    // R8: load full table while stopped
    for (int i = 0; i < DEPTH; i++)
      wr(i[ADDR_W-1:0], 4'((i ^ (i >> 3) ^ (i >> 6)) & 15));
    // R3: level 7 entries never reported
    wr({3'd2, 1'b0, 3'd1, 3'd4}, 4'hF);
    wr({3'd2, 1'b1, 3'd1, 3'd5}, 4'h7);
    look("R3", 1'b1, 3'd2, 3'd1, 2'b11, 3'd4, 3'd5);
    // R5: tie goes to candidate 0 with its sign
    idle("R5", 1'b1);
    wr({3'd5, 1'b0, 3'd6, 3'd2}, 4'hB);
    wr({3'd5, 1'b1, 3'd6, 3'd3}, 4'h3);
    look("R5", 1'b1, 3'd5, 3'd6, 2'b11, 3'd2, 3'd3);
    // R5: higher level on candidate 1 wins
    idle("R5", 1'b1);
    wr({3'd5, 1'b1, 3'd6, 3'd3}, 4'h6);
    look("R5", 1'b1, 3'd5, 3'd6, 2'b11, 3'd2, 3'd3);
    // R4: hit flags gate candidates
    look("R4", 1'b0, 3'd5, 3'd6, 2'b11, 3'd2, 3'd3);
    look("R4", 1'b1, 3'd5, 3'd6, 2'b00, 3'd2, 3'd3);
    look("R4", 1'b1, 3'd5, 3'd6, 2'b01, 3'd2, 3'd3);
    // R8: write while running is ignored, even at the address being looked up
    a = {3'd5, 1'b0, 3'd6, 3'd2};
    cyc("R8", 1'b1, 1'b1, a, 4'h1, 1'b1, 1'b1, 3'd5, 3'd6, 2'b01, 3'd2, 3'd0);
    look("R8", 1'b1, 3'd5, 3'd6, 2'b01, 3'd2, 3'd0);
    // R6: valid without run gives nothing
    cyc("R6", 1'b0, 1'b0, '0, 4'd0, 1'b1, 1'b1, 3'd5, 3'd6, 2'b11, 3'd2, 3'd3);
    idle("R6", 1'b0);
    // R1 R5 R7: random back-to-back lookups with occasional reloads
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0)
        cyc("R8", 1'b0, 1'b1, ADDR_W'($urandom), 4'($urandom), 1'($urandom), 1'b1,
            3'($urandom), RDEV_W'($urandom), 2'($urandom), PDEV_W'($urandom), PDEV_W'($urandom));
      else
        cyc("R1 R5 R7", 1'b1, 1'($urandom_range(0, 7) == 0), ADDR_W'($urandom), 4'($urandom),
            1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 7) != 0), 3'($urandom),
            RDEV_W'($urandom), 2'($urandom), PDEV_W'($urandom), PDEV_W'($urandom));
    end
    idle("R6", 1'b1);
    idle("R6", 1'b1);
    idle("R6", 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule